// File: doc/BRIEF.md
# Time-of-Day Alarm with Repeat Masks

This unit keeps four alarm bytes (seconds, minutes, hours and day of month) in BCD. Once per second it compares them with the current BCD time supplied by an external calendar counter. When the fields taking part in the comparison all agree, it drives a one-cycle interrupt pulse. Bit 7 of each alarm byte is a mask flag. The pattern of mask flags across the four bytes sets the repeat rate: monthly, daily, hourly, every minute or every second.

Software loads the alarm bytes through a byte-wide write port and reads them back through a separate read port that has its own field select. A write whose BCD content is out of range for its field is dropped, and the stored byte stays as it was. The `tick` input is a one-cycle pulse given once per second. The comparison is made only in a cycle where `tick` is high. The calendar counter, interrupt routing and any battery-backed storage are outside this block.

Top module: `rtc_alarm`

## Requirements
- R1: The field select on `wr_sel` and `rd_sel` is encoded as 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores the whole byte, mask bit 7 included. `rd_data` shows the byte stored for `rd_sel`, starting in the cycle after the write edge.
- R2: A seconds or minutes write uses bits 6:0 as BCD (tens in 6:4, units in 3:0). It is accepted only when the units digit is at most 9 and the value is 0 to 59.
- R3: An hours write uses bits 5:0 as BCD (tens in 5:4). It is accepted only when the units digit is at most 9 and the value is 0 to 23.
- R4: A date write uses bits 5:0 as BCD. It is accepted only when those bits are nonzero and the units digit is at most 9.
- R5: A rejected write leaves the stored byte for that field unchanged.
- R6: With no mask bit set, a tick raises the interrupt only when seconds, minutes, hours and date all match.
- R7: With only the date mask set, the date is ignored and seconds, minutes and hours must match (daily repeat).
- R8: With the date and hours masks set and the others clear, only seconds and minutes must match (hourly repeat).
- R9: With the date, hours and minutes masks set and the seconds mask clear, only seconds must match (repeat each minute).
- R10: Any other mask combination makes every tick raise the interrupt (repeat each second).
- R11: `irq` is high for exactly one cycle: the cycle after the clock edge that samples `tick` high together with a match. Without a tick, `irq` stays low.
- R12: Synchronous reset clears all four alarm bytes and holds `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one alarm byte |
| wr_sel | input | 2 | Field to write (0 sec, 1 min, 2 hour, 3 date) |
| wr_data | input | 8 | Byte to write; bit 7 is the repeat mask |
| rd_sel | input | 2 | Field to read back |
| rd_data | output | 8 | Stored byte for `rd_sel` |
| tick | input | 1 | One-cycle pulse, once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A write is seen on `rd_data` one edge after the strobe, because the read mux is combinational over the stored bytes. The bench therefore drives a write at one falling edge, releases it at the next, and only then reads back. `irq` is registered. When `tick` is driven at a falling edge, the following falling edge is where the expected pulse level is checked, and the falling edge after that is where `irq` must be low again. Each vector also reloads all four alarm bytes before its tick, so no result depends on a previous vector.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int BYTE_W  = 8;
    localparam int FIELDS  = 4;
    localparam int SEL_W   = $clog2(FIELDS);
    localparam int MASK_B  = BYTE_W - 1;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MINUTE,
        RPT_SECOND
    } rate_e;

    typedef logic [FIELDS-1:0][BYTE_W-1:0] tod_bytes_t;

    // BCD bits that take part in comparison for a field
    function automatic logic [BYTE_W-1:0] value_bits(input field_e f);
        case (f)
            FLD_SEC, FLD_MIN: value_bits = 8'h7F;
            default:          value_bits = 8'h3F;
        endcase
    endfunction

    // Range check applied before a byte is stored
    function automatic logic byte_ok(input field_e f, input logic [BYTE_W-1:0] b);
        logic [3:0] units;
        logic [2:0] tens;
        units = b[3:0];
        tens  = b[6:4];
        case (f)
            FLD_SEC, FLD_MIN: byte_ok = (units <= 4'd9) && (tens <= 3'd5);
            FLD_HOUR:         byte_ok = (units <= 4'd9) &&
                                        ((b[5:4] < 2'd2) || (b[5:4] == 2'd2 && units <= 4'd3));
            default:          byte_ok = (units <= 4'd9) && (b[5:0] != 6'd0);
        endcase
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output tod_bytes_t        alarm_q
);

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        localparam field_e FID = field_e'(i);
        logic take;
        assign take = wr_en && (wr_sel == SEL_W'(i)) && byte_ok(FID, wr_data);

        always_ff @(posedge clk) begin
            if (rst)
                alarm_q[i] <= '0;
            else if (take)
                alarm_q[i] <= wr_data;
        end
    end

    assign rd_data = alarm_q[rd_sel];

endmodule

// File: rtl/rtc_alarm_rate.sv
module rtc_alarm_rate
    import rtc_alarm_pkg::*;
(
    input  logic [FIELDS-1:0] mask,
    output logic [FIELDS-1:0] cmp_en
);

    rate_e rate;

    // mask bit order: [3]=date [2]=hour [1]=min [0]=sec
    always_comb begin
        case (mask)
            4'b0000: rate = RPT_MONTH;
            4'b1000: rate = RPT_DAY;
            4'b1100: rate = RPT_HOUR;
            4'b1110: rate = RPT_MINUTE;
            default: rate = RPT_SECOND;
        endcase
    end

    always_comb begin
        case (rate)
            RPT_MONTH:  cmp_en = 4'b1111;
            RPT_DAY:    cmp_en = 4'b0111;
            RPT_HOUR:   cmp_en = 4'b0011;
            RPT_MINUTE: cmp_en = 4'b0001;
            default:    cmp_en = 4'b0000;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tod_bytes_t        alarm_q,
    input  tod_bytes_t        now,
    input  logic [FIELDS-1:0] cmp_en,
    output logic              irq
);

    logic [FIELDS-1:0] field_hit;

    for (genvar i = 0; i < FIELDS; i++) begin : g_cmp
        localparam logic [BYTE_W-1:0] VB = value_bits(field_e'(i));
        assign field_hit[i] = !cmp_en[i] || ((alarm_q[i] & VB) == (now[i] & VB));
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= tick && (&field_hit);
    end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic        tick,
    input  logic [7:0]  cur_sec,
    input  logic [7:0]  cur_min,
    input  logic [7:0]  cur_hour,
    input  logic [7:0]  cur_date,
    output logic        irq
);

    tod_bytes_t        alarm_q;
    tod_bytes_t        now;
    logic [FIELDS-1:0] mask;
    logic [FIELDS-1:0] cmp_en;

    assign now = {cur_date, cur_hour, cur_min, cur_sec};

    for (genvar i = 0; i < FIELDS; i++) begin : g_mask
        assign mask[i] = alarm_q[i][MASK_B];
    end

    rtc_alarm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .alarm_q (alarm_q)
    );

    rtc_alarm_rate u_rate (
        .mask   (mask),
        .cmp_en (cmp_en)
    );

    rtc_alarm_match u_match (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .alarm_q (alarm_q),
        .now     (now),
        .cmp_en  (cmp_en),
        .irq     (irq)
    );

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        irq,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [7:0]  wr_data,
    input tod_bytes_t  alarm_q
);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r11_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !irq);

    a_r10_all_masked: assert property (@(posedge clk) disable iff (rst)
        (tick && alarm_q[0][7] && alarm_q[1][7] && alarm_q[2][7] && alarm_q[3][7]) |=> irq);

    a_r2_sec_reject: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && wr_data[6:4] > 3'd5) |=> $stable(alarm_q[0]));

    a_r3_hour_reject: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && wr_data[5:4] == 2'd3) |=> $stable(alarm_q[2]));

    a_r4_date_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3 && wr_data[5:0] == 6'd0) |=> $stable(alarm_q[3]));

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq && alarm_q == '0));

endmodule

bind rtc_alarm rtc_alarm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .irq     (irq),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .alarm_q (alarm_q)
);

// File: tb/sim_rtc_alarm.sv
`timescale 1ns/1ps
module sim_rtc_alarm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = 8'h01;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_alarm u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .irq(irq)
    );

    // {a_sec,a_min,a_hr,a_dt, c_sec,c_min,c_hr,c_dt, expect}
    localparam int NV = 11;
    localparam logic [64:0] VECS [0:NV-1] = '{
        {8'h30,8'h45,8'h12,8'h15, 8'h30,8'h45,8'h12,8'h15, 1'b1}, // R6 full match
        {8'h30,8'h45,8'h12,8'h15, 8'h30,8'h45,8'h12,8'h16, 1'b0}, // R6 date differs
        {8'h30,8'h45,8'h12,8'h95, 8'h30,8'h45,8'h12,8'h03, 1'b1}, // R7 date ignored
        {8'h30,8'h45,8'h12,8'h95, 8'h30,8'h45,8'h13,8'h15, 1'b0}, // R7 hour differs
        {8'h30,8'h45,8'h92,8'h95, 8'h30,8'h45,8'h07,8'h22, 1'b1}, // R8 hour ignored
        {8'h30,8'h45,8'h92,8'h95, 8'h30,8'h44,8'h12,8'h15, 1'b0}, // R8 minute differs
        {8'h30,8'hC5,8'h92,8'h95, 8'h30,8'h10,8'h01,8'h02, 1'b1}, // R9 seconds only
        {8'h30,8'hC5,8'h92,8'h95, 8'h31,8'h45,8'h12,8'h15, 1'b0}, // R9 seconds differ
        {8'hB0,8'hC5,8'h92,8'h95, 8'h01,8'h02,8'h03,8'h04, 1'b1}, // R10 all masked
        {8'hB0,8'h45,8'h12,8'h15, 8'h01,8'h02,8'h03,8'h04, 1'b1}, // R10 seconds mask only
        {8'h30,8'h45,8'h92,8'h15, 8'h01,8'h02,8'h03,8'h04, 1'b1}  // R10 hours mask only
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic fire(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input logic exp, input string req);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(req, {7'd0, irq}, {7'd0, exp});
        @(negedge clk);
        check("R11 pulse ends", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check("R12 irq after reset", {7'd0, irq}, 8'h00);
        for (int f = 0; f < 4; f++) rd_check("R12 cleared byte", 2'(f), 8'h00);

        // R1 readback including mask bit
        wr(2'd1, 8'hD9);
        rd_check("R1 minutes stored with mask", 2'd1, 8'hD9);

        // R2 seconds / minutes range
        wr(2'd0, 8'h59);
        rd_check("R2 sec 59 accepted", 2'd0, 8'h59);
        wr(2'd0, 8'h60);
        rd_check("R2 R5 sec 60 rejected", 2'd0, 8'h59);
        wr(2'd0, 8'h5A);
        rd_check("R2 R5 sec units A rejected", 2'd0, 8'h59);
        wr(2'd1, 8'h7F);
        rd_check("R2 R5 min 7F rejected", 2'd1, 8'hD9);

        // R3 hours range
        wr(2'd2, 8'h23);
        rd_check("R3 hour 23 accepted", 2'd2, 8'h23);
        wr(2'd2, 8'h24);
        rd_check("R3 R5 hour 24 rejected", 2'd2, 8'h23);
        wr(2'd2, 8'h1A);
        rd_check("R3 R5 hour 1A rejected", 2'd2, 8'h23);
        wr(2'd2, 8'hA3);
        rd_check("R3 masked hour accepted", 2'd2, 8'hA3);

        // R4 date range
        wr(2'd3, 8'h31);
        rd_check("R4 date 31 accepted", 2'd3, 8'h31);
        wr(2'd3, 8'h00);
        rd_check("R4 R5 date 00 rejected", 2'd3, 8'h31);
        wr(2'd3, 8'h80);
        rd_check("R4 R5 masked date 00 rejected", 2'd3, 8'h31);
        wr(2'd3, 8'h39);
        rd_check("R4 date 39 accepted", 2'd3, 8'h39);

        // Vector table: R6..R10 with R11 pulse shape
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, VECS[v][64:57]);
            wr(2'd1, VECS[v][56:49]);
            wr(2'd2, VECS[v][48:41]);
            wr(2'd3, VECS[v][40:33]);
            fire(VECS[v][32:25], VECS[v][24:17], VECS[v][16:9], VECS[v][8:1],
                 VECS[v][0], $sformatf("R6-10 vector %0d", v));
        end

        // R11 no tick, matching time: irq stays low
        wr(2'd0, 8'h10); wr(2'd1, 8'h20); wr(2'd2, 8'h08); wr(2'd3, 8'h05);
        @(negedge clk);
        cur_sec = 8'h10; cur_min = 8'h20; cur_hour = 8'h08; cur_date = 8'h05;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R11 no pulse without tick", {7'd0, irq}, 8'h00);
        end
        fire(8'h10, 8'h20, 8'h08, 8'h05, 1'b1, "R11 R6 pulse on tick");

        // R12 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12 irq low after reset", {7'd0, irq}, 8'h00);
        for (int f = 0; f < 4; f++) rd_check("R12 byte cleared", 2'(f), 8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule